// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Abort Capture

This block holds the interrupt state of an I2C bus controller. The controller datapath sends single-cycle event strobes, a transmit-abort cause vector and the fill levels of its receive and transmit FIFOs. Ten of the twelve status bits are sticky flags set by those strobes. The other two follow the FIFO levels compared against programmable thresholds. A mask register selects which raw bits reach the masked status. The single interrupt line is the registered OR of that masked status.

Software clears a sticky flag by reading the dedicated clear address of that flag. A clear read returns the prior value of the flag in bit 0. One further address clears every sticky flag at once. When a transmit abort occurs, the block records its cause bits in an abort-source register. That register keeps its value until software acknowledges the abort through its clear read.

The register port is a plain strobe interface. Reads and writes take effect on the rising clock edge, and read data is registered.

Top module: `i2c_irq_abort_unit`

## Requirements
- R1: Status bit positions are: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. For every bit except 2 and 4, a high `evt_i[k]` at a clock edge sets raw bit k, and the bit stays set until it is cleared by a read. `evt_i[2]` and `evt_i[4]` have no effect.
- R2: Raw bit 2 (rx_full) is 1 while `rx_level_i` is greater than the receive threshold. Raw bit 4 (tx_empty) is 1 while `tx_level_i` is less than or equal to the transmit threshold. Both bits are registered one edge after the comparison, and no clear read changes them.
- R3: Reading offset 0x34 returns the raw status in bits 11:0. Offset 0x30 returns the mask. Offset 0x2C returns the raw status ANDed with the mask.
- R4: Each sticky bit has a clear address. In bit order these are 0x44 (bit 0), 0x48 (1), 0x4C (3), 0x50 (5), 0x54 (6), 0x58 (7), 0x5C (8), 0x60 (9), 0x64 (10) and 0x68 (11). A read of one of these addresses clears only that bit and returns the bit's value from before the clear in read-data bit 0.
- R5: A read of offset 0x40 clears all ten sticky bits. It returns in bit 0 the OR of the sticky bits from before the clear.
- R6: If an event strobe arrives in the same cycle as a clear read that would clear its bit, the bit ends up set.
- R7: `irq_o` is registered. After each edge it equals the OR of (raw AND mask) as they stood before that edge. It is 0 whenever the mask was all zeros.
- R8: When `evt_i[6]` is high, the cause bits of `abrt_cause_i` are ORed into the abort-source register, which reads back at 0x80. Only bits 0–5, 7 and 9–12 are kept. Bits 6 and 8 always read 0.
- R9: The abort-source register changes only on an abort strobe or on a read of 0x54 or 0x40, and either of those reads clears it. When a clear read and an abort strobe happen in the same cycle, the register ends up holding only the new cause bits.
- R10: Writes to 0x30 load the mask from `reg_wdata_i[11:0]`. Writes to 0x38 and 0x3C load the receive and transmit thresholds from the low LVL_W bits, and those thresholds read back zero-extended at the same offsets. Writes to any other offset change nothing.
- R11: After reset the sticky bits, mask, thresholds, abort source, read data and `irq_o` are all 0.
- R12: `reg_rdata_o` holds the read result in the cycle after a read strobe. It is 0 after any edge without a read, and unknown offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12 | Event strobes, one per status bit |
| abrt_cause_i | input | 13 | Abort cause bits, sampled with evt_i[6] |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| reg_addr_i | input | 8 | Register byte offset |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 12 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Each result has a fixed due cycle. Raw status, threshold comparisons, the abort register, clears and read data all change on the first rising edge after the stimulus. `irq_o` follows one edge after the raw and mask values it reflects, so it is due two edges after an event strobe.

The bench drives every input at the falling edge and advances its own model at the next rising edge. It compares `reg_rdata_o` and `irq_o` at the following falling edge, which is exactly one register stage after the stimulus, in every cycle. Directed sequences cover the same-cycle set-and-clear cases, the threshold boundaries and abort accumulation. A seeded random phase mixes events, reads and writes.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_EVT = 12;
    localparam int ABRT_W  = 13;
    localparam int ADDR_W  = 8;
    localparam int RDATA_W = 32;

    localparam int EV_RX_FULL  = 2;
    localparam int EV_TX_EMPTY = 4;
    localparam int EV_TX_ABRT  = 6;

    // bits driven by FIFO levels versus bits latched from strobes
    localparam logic [NUM_EVT-1:0] LEVEL_MAP = 12'h014;
    localparam logic [NUM_EVT-1:0] LATCH_MAP = 12'hFEB;
    // abort cause bits that are recorded (6 and 8 are unused)
    localparam logic [ABRT_W-1:0]  ABRT_KEEP = 13'h1EBF;

    localparam logic [ADDR_W-1:0] OFS_MASKED   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_RAW      = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_RX_THR   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_TX_THR   = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_CLR_ALL  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_CLR_BASE = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_ABRT     = 8'h80;

    // clear address of a sticky bit: consecutive words, skipping level bits
    function automatic logic [ADDR_W-1:0] clr_addr_of(input int idx);
        int rank;
        rank = idx - ((idx > EV_RX_FULL) ? 1 : 0) - ((idx > EV_TX_EMPTY) ? 1 : 0);
        return ADDR_W'(int'(OFS_CLR_BASE) + 4 * rank);
    endfunction
endpackage

// File: rtl/i2c_irq_evt_bits.sv
module i2c_irq_evt_bits
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_i,
    input  logic [NUM_EVT-1:0] clr_i,
    input  logic [NUM_EVT-1:0] lvl_i,
    output logic [NUM_EVT-1:0] raw_o
);
    logic [NUM_EVT-1:0] raw_q;
    logic [NUM_EVT-1:0] raw_d;

    // sticky bits: set beats clear; level bits: follow the comparison
    always_comb begin
        raw_d = (LATCH_MAP & ((raw_q & ~clr_i) | set_i)) | (LEVEL_MAP & lvl_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/i2c_irq_abort_capture.sv
module i2c_irq_abort_capture
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [ABRT_W-1:0] cause_i,
    input  logic              clear_i,
    output logic [ABRT_W-1:0] src_o
);
    logic [ABRT_W-1:0] src_q;
    logic [ABRT_W-1:0] base;

    always_comb begin
        base = clear_i ? '0 : src_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         src_q <= '0;
        else if (capture_i) src_q <= base | (cause_i & ABRT_KEEP);
        else                src_q <= base;
    end

    assign src_o = src_q;
endmodule

// File: rtl/i2c_irq_reg_port.sv
module i2c_irq_reg_port
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [NUM_EVT-1:0] wdata_i,
    input  logic [NUM_EVT-1:0] raw_i,
    input  logic [ABRT_W-1:0]  abrt_i,
    output logic [NUM_EVT-1:0] mask_o,
    output logic [LVL_W-1:0]   rx_thr_o,
    output logic [LVL_W-1:0]   tx_thr_o,
    output logic [NUM_EVT-1:0] clr_o,
    output logic               abrt_clr_o,
    output logic [RDATA_W-1:0] rdata_o
);
    logic [NUM_EVT-1:0] mask_q;
    logic [LVL_W-1:0]   rx_thr_q;
    logic [LVL_W-1:0]   tx_thr_q;
    logic [RDATA_W-1:0] rdata_q;
    logic [RDATA_W-1:0] rd_mux;
    logic               clr_all;

    assign clr_all = rd_i && (addr_i == OFS_CLR_ALL);

    // one clear decoder per sticky bit
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_clr
        if (LATCH_MAP[k]) begin : g_sticky
            assign clr_o[k] = clr_all || (rd_i && (addr_i == clr_addr_of(k)));
        end else begin : g_level
            assign clr_o[k] = 1'b0;
        end
    end

    assign abrt_clr_o = clr_o[EV_TX_ABRT];

    always_comb begin
        rd_mux = '0;
        unique case (addr_i)
            OFS_MASKED:  rd_mux[NUM_EVT-1:0] = raw_i & mask_q;
            OFS_MASK:    rd_mux[NUM_EVT-1:0] = mask_q;
            OFS_RAW:     rd_mux[NUM_EVT-1:0] = raw_i;
            OFS_RX_THR:  rd_mux[LVL_W-1:0]   = rx_thr_q;
            OFS_TX_THR:  rd_mux[LVL_W-1:0]   = tx_thr_q;
            OFS_CLR_ALL: rd_mux[0]           = |(raw_i & LATCH_MAP);
            OFS_ABRT:    rd_mux[ABRT_W-1:0]  = abrt_i;
            default: begin
                for (int k = 0; k < NUM_EVT; k++) begin
                    if (LATCH_MAP[k] && (addr_i == clr_addr_of(k))) rd_mux[0] = raw_i[k];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            rx_thr_q <= '0;
            tx_thr_q <= '0;
            rdata_q  <= '0;
        end else begin
            rdata_q <= rd_i ? rd_mux : '0;
            if (wr_i) begin
                unique case (addr_i)
                    OFS_MASK:   mask_q   <= wdata_i;
                    OFS_RX_THR: rx_thr_q <= wdata_i[LVL_W-1:0];
                    OFS_TX_THR: tx_thr_q <= wdata_i[LVL_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    assign mask_o   = mask_q;
    assign rx_thr_o = rx_thr_q;
    assign tx_thr_o = tx_thr_q;
    assign rdata_o  = rdata_q;
endmodule

// File: rtl/i2c_irq_abort_unit.sv
module i2c_irq_abort_unit
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [ABRT_W-1:0]  abrt_cause_i,
    input  logic [LVL_W-1:0]   rx_level_i,
    input  logic [LVL_W-1:0]   tx_level_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_rd_i,
    input  logic               reg_wr_i,
    input  logic [NUM_EVT-1:0] reg_wdata_i,
    output logic [RDATA_W-1:0] reg_rdata_o,
    output logic               irq_o
);
    logic [NUM_EVT-1:0] raw_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] lvl_vec;
    logic [LVL_W-1:0]   rx_thr;
    logic [LVL_W-1:0]   tx_thr;
    logic [ABRT_W-1:0]  abrt_q;
    logic               abrt_clr;
    logic               irq_q;

    always_comb begin
        lvl_vec              = '0;
        lvl_vec[EV_RX_FULL]  = rx_level_i > rx_thr;
        lvl_vec[EV_TX_EMPTY] = tx_level_i <= tx_thr;
    end

    i2c_irq_evt_bits u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_i),
        .clr_i (clr_vec),
        .lvl_i (lvl_vec),
        .raw_o (raw_q)
    );

    i2c_irq_abort_capture u_abrt (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (evt_i[EV_TX_ABRT]),
        .cause_i   (abrt_cause_i),
        .clear_i   (abrt_clr),
        .src_o     (abrt_q)
    );

    i2c_irq_reg_port #(.LVL_W(LVL_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (reg_addr_i),
        .rd_i       (reg_rd_i),
        .wr_i       (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .raw_i      (raw_q),
        .abrt_i     (abrt_q),
        .mask_o     (mask_q),
        .rx_thr_o   (rx_thr),
        .tx_thr_o   (tx_thr),
        .clr_o      (clr_vec),
        .abrt_clr_o (abrt_clr),
        .rdata_o    (reg_rdata_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(raw_q & mask_q);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/i2c_irq_abort_unit_chk.sv
module i2c_irq_abort_unit_chk
    import i2c_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               reg_rd_i,
    input logic [RDATA_W-1:0] reg_rdata_o,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] raw_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic [ABRT_W-1:0]  abrt_q
);
    AST_STICKY_RX_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[0] && !(reg_rd_i && (reg_addr_i == 8'h44 || reg_addr_i == 8'h40))) |=> raw_q[0]); // R1
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[9] |=> raw_q[9]); // R6
    AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_o); // R7
    AST_ABRT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i[6] && !(reg_rd_i && (reg_addr_i == 8'h54 || reg_addr_i == 8'h40))) |=> $stable(abrt_q)); // R9
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_i |=> (reg_rdata_o == '0)); // R12
endmodule

bind i2c_irq_abort_unit i2c_irq_abort_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .raw_q       (raw_q),
    .mask_q      (mask_q),
    .abrt_q      (abrt_q)
);

// File: tb/i2c_irq_abort_unit_test.sv
module i2c_irq_abort_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt = '0;
    logic [12:0] cause = '0;
    logic [LVL_W-1:0] rxl = '0, txl = '0;
    logic [7:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [11:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, fails = 0;

    // bench model state
    logic [11:0] m_raw = '0, m_mask = '0;
    logic [LVL_W-1:0] m_rxthr = '0, m_txthr = '0;
    logic [12:0] m_abrt = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_irq_abort_unit #(.LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .abrt_cause_i(cause),
        .rx_level_i(rxl), .tx_level_i(txl), .reg_addr_i(addr),
        .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // clear address of each sticky bit, -1 when none
    function automatic int bit_of_clr(input logic [7:0] a);
        case (a)
            8'h44: return 0;  8'h48: return 1;  8'h4C: return 3;
            8'h50: return 5;  8'h54: return 6;  8'h58: return 7;
            8'h5C: return 8;  8'h60: return 9;  8'h64: return 10;
            8'h68: return 11; default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int b;
        b = bit_of_clr(a);
        if (b >= 0) return {31'b0, m_raw[b]};
        case (a)
            8'h2C: return {20'b0, m_raw & m_mask};
            8'h30: return {20'b0, m_mask};
            8'h34: return {20'b0, m_raw};
            8'h38: return {27'b0, m_rxthr};
            8'h3C: return {27'b0, m_txthr};
            8'h40: return {31'b0, |(m_raw & 12'hFEB)};
            8'h80: return {19'b0, m_abrt};
            default: return 32'b0;
        endcase
    endfunction

    task automatic model_edge();
        logic [11:0] clr;
        logic [11:0] nraw;
        int b;
        clr = '0;
        if (rd) begin
            b = bit_of_clr(addr);
            if (b >= 0) clr[b] = 1'b1;
            if (addr == 8'h40) clr = 12'hFEB;
        end
        m_rdata = rd ? exp_read(addr) : 32'b0;
        m_irq   = |(m_raw & m_mask);
        nraw    = ((m_raw & ~clr) | evt) & 12'hFEB;
        nraw[2] = rxl > m_rxthr;
        nraw[4] = txl <= m_txthr;
        if (clr[6]) m_abrt = '0;
        if (evt[6]) m_abrt = m_abrt | (cause & 13'h1EBF);
        m_raw = nraw;
        if (wr) begin
            if (addr == 8'h30) m_mask  = wdata;
            if (addr == 8'h38) m_rxthr = wdata[LVL_W-1:0];
            if (addr == 8'h3C) m_txthr = wdata[LVL_W-1:0];
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: called at a falling edge, returns at the next falling edge
    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " rdata"}, rdata, m_rdata);
        check({tag, " irq"}, {31'b0, irq}, {31'b0, m_irq});
        evt = '0; cause = '0; rd = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, input string tag);
        addr = a; rd = 1'b1; cyc(tag);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [11:0] v, input string tag);
        addr = a; wr = 1'b1; wdata = v; cyc(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] pick [18];
        pick = '{8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C,
                 8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68, 8'h80, 8'h20};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R11 irq in reset", {31'b0, irq}, 32'b0);
        check("R11 rdata in reset", rdata, 32'b0);
        rst_n = 1'b1;
        cyc("R11 first cycle");
        rd_reg(8'h34, "R11 raw after reset");
        rd_reg(8'h30, "R11 mask after reset");
        rd_reg(8'h80, "R11 abort after reset");
        rd_reg(8'h38, "R11 rx threshold");
        rd_reg(8'h77, "R12 unknown offset");
        cyc("R12 idle read data");

        evt = 12'h215; cyc("R1 events 0,2,4,9");   // bits 2,4 strobes ignored
        rd_reg(8'h34, "R1 raw sticky");
        rd_reg(8'h44, "R4 clear rx_under returns 1");
        rd_reg(8'h44, "R4 second clear returns 0");
        rd_reg(8'h34, "R4 only own bit cleared");

        evt[9] = 1'b1; rd_reg(8'h60, "R6 set with clear");
        rd_reg(8'h34, "R6 bit stays set");

        evt = 12'hFFF; cyc("R5 set all");
        rd_reg(8'h40, "R5 clear all returns 1");
        rd_reg(8'h34, "R5 all sticky cleared");
        rd_reg(8'h40, "R5 clear all returns 0");

        wr_reg(8'h38, 12'd4, "R10 write rx thr");
        wr_reg(8'h3C, 12'd3, "R10 write tx thr");
        rd_reg(8'h38, "R10 rx thr readback");
        rxl = 5'd4; txl = 5'd3; cyc("R2 at thresholds");
        rd_reg(8'h34, "R2 rx 4 not full, tx 3 empty");
        rxl = 5'd5; txl = 5'd4; cyc("R2 above thresholds");
        rd_reg(8'h4C, "R2 clear of tx_over only");
        rd_reg(8'h34, "R2 rx full, tx not empty");
        wr_reg(8'h34, 12'h000, "R10 write to raw ignored");
        rd_reg(8'h34, "R10 raw unchanged");

        wr_reg(8'h30, 12'h200, "R3 mask stop_det");
        evt[9] = 1'b1; cyc("R7 event");
        cyc("R7 irq rises");
        rd_reg(8'h2C, "R3 masked status");
        rd_reg(8'h60, "R7 clear stop_det");
        cyc("R7 irq falls");
        wr_reg(8'h30, 12'h000, "R7 mask off");

        evt[6] = 1'b1; cause = 13'h0001; cyc("R8 abort one");
        evt[6] = 1'b1; cause = 13'h1FFE; cyc("R8 abort accumulate");
        repeat (3) cyc("R9 idle hold");
        rd_reg(8'h80, "R8 abort source 0x1EBF");
        rd_reg(8'h54, "R9 tx_abrt clear returns 1");
        rd_reg(8'h80, "R9 abort cleared");
        evt[6] = 1'b1; cause = 13'h0008; cyc("R8 abort");
        evt[6] = 1'b1; cause = 13'h1000; rd_reg(8'h54, "R9 clear with new abort");
        rd_reg(8'h80, "R9 new cause only");
        rd_reg(8'h40, "R9 clear all");
        rd_reg(8'h80, "R9 cleared by 0x40");

        for (int i = 0; i < 3000; i++) begin
            evt   = 12'($urandom & $urandom & $urandom);
            cause = 13'($urandom);
            rxl   = LVL_W'($urandom);
            txl   = LVL_W'($urandom);
            addr  = pick[$urandom % 18];
            rd    = ($urandom % 2) == 0;
            wr    = ($urandom % 4) == 0;
            wdata = 12'($urandom);
            cyc("R3 R7 random");
        end
        finish_run();
    end
endmodule